// File: doc/BRIEF.md
# Clock Domain Sleep/Wake Controller

This block governs the sleep and wake state of a small group of clock domains. Each domain has its own control word, which software writes through a simple valid/ready register port. A 2-bit transition field selects one of four behaviours: hold the present state, forced sleep, forced wake, or hardware-automatic sleep and wake. A second 2-bit field selects the module mode. The clock of each domain is modelled as a gate-enable output. Each domain also runs an idle request and acknowledge handshake with the module it contains, and gates a separate module clock enable according to the module mode.

Domains keep one another awake in two ways. Software sets static dependency bits: an active source domain holds every destination it names. Interconnect traffic lines give a dynamic dependency: a destination stays awake while traffic from a source is present. Each domain reports clock activity, module-awake and clock-enable status, together with the live traffic lines it drives as a source. A clock-activity bit is set while the clock runs, and also during the gating and ungating cycles.

Top module: `domain_clock_ctrl`

## Requirements
- R1: After synchronous reset every domain is asleep: clk_en, clk_active, mod_clk_en are 0, idle_req is 1, and all control and dependency registers read 0.
- R2: Transition field value 0 (bits [1:0] of the control word) starts no transition: an asleep domain stays asleep even with a wake request or a dependency present.
- R3: Transition field value 2 forces a wake: the cycle after the control word takes effect, clk_active rises while clk_en is still 0 (ungating), and clk_en rises one cycle later.
- R4: While the module mode field (control bits [3:2]) is 0 the domain may be awake, but idle_req stays 1, mod_clk_en stays 0 and the module-awake status bit stays 0.
- R5: With module mode 1 (automatic interface gating) or 2 (always on) on an awake domain, idle_req falls one cycle later. The module-awake bit sets only in the cycle after idle_ack is seen low. With mode 2 mod_clk_en follows clk_en. With mode 1 it is 1 only while idle_req is low.
- R6: Transition field value 3 puts a domain with no wake request and no dependency to sleep. idle_req rises while clk_en stays 1 until idle_ack is seen high. Then one cycle has clk_en 0 with clk_active 1, and then clk_active falls.
- R7: With transition field value 3, a wake_req bit wakes a sleeping domain and brings its module up through the handshake; dropping the request lets the domain sleep again.
- R8: Static dependency register bit j of source domain i (register select 1) holds domain j awake while domain i is active; it has no effect while domain i is asleep.
- R9: bus_traffic bit i*N_DOM+j (source i to destination j) wakes destination j one cycle after it is set and holds it while set. The status word of domain i shows these bits at bit 8+j.
- R10: Transition field value 1 forces sleep only while no dependency holds the domain; while a dependency holds it, the domain is kept or made active.
- R11: A static dependency bit naming the domain's own index has no effect.
- R12: Address is domain*4 + select. Select 0 (control, 4 bits) and select 1 (dependency, N_DOM bits) read back what was written. Select 2 is the read-only status word: bit 0 clk_active, bit 1 module awake, bit 2 clk_en, bits 8 and up traffic. Select 3, and indexes of domains that do not exist, read 0. Read data and rd_resp_valid appear one cycle after the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | AW (4) | Write address, domain*4 + select |
| wr_data | input | DW (32) | Write data |
| rd_valid | input | 1 | Register read request |
| rd_ready | output | 1 | Read accepted (always 1) |
| rd_addr | input | AW (4) | Read address |
| rd_data | output | DW (32) | Read data, one cycle after request |
| rd_resp_valid | output | 1 | Read data valid |
| wake_req | input | N_DOM (3) | Hardware wake request per domain |
| idle_ack | input | N_DOM (3) | Module idle acknowledge per domain |
| bus_traffic | input | N_DOM*N_DOM (9) | Interconnect traffic, bit i*N_DOM+j from source i to destination j |
| clk_en | output | N_DOM (3) | Domain clock gate enable |
| mod_clk_en | output | N_DOM (3) | Module clock gate enable |
| idle_req | output | N_DOM (3) | Idle request to module |
| clk_active | output | N_DOM (3) | Clock running or in a gating transition |

## Verification
The bench measures the exact cycle of each gating edge. A controller that dropped the clock at once, without a gating cycle, would lose the activity bit one cycle early. One that gated before the idle acknowledge would stop clocking a busy module. The bench holds idle_ack high while the module mode is enabled. A design that called the module awake without waiting for the acknowledge to drop would then set the awake status too early. A dependency from a sleeping source, a dependency on the domain itself, and forced sleep against a live dependency are each exercised; a wrong design would wake a domain nobody needs, keep a domain awake forever, or gate a domain another domain still uses. Writes to the read-only status word and reads of unmapped addresses must return zero.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    TM_KEEP  = 2'd0,
    TM_SLEEP = 2'd1,
    TM_WAKE  = 2'd2,
    TM_AUTO  = 2'd3
  } tmode_t;

  typedef enum logic [2:0] {
    ST_OFF, ST_UNGATE, ST_ON, ST_WAKING, ST_RUN, ST_IDLING, ST_GATE
  } dstate_t;

  localparam logic [1:0] MM_OFF      = 2'd0;
  localparam logic [1:0] MM_AUTOGATE = 2'd1;
  localparam logic [1:0] MM_ON       = 2'd2;

  localparam int CTRL_W   = 4;
  localparam int STAT_TRB = 8;
endpackage

// File: rtl/dcc_regs.sv
module dcc_regs #(
  parameter int N_DOM = 3,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_valid,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_resp_valid,
  input  logic [N_DOM-1:0]         act,
  input  logic [N_DOM-1:0]         awake,
  input  logic [N_DOM-1:0]         clk_on,
  input  logic [N_DOM*N_DOM-1:0]   traffic,
  output logic [4*N_DOM-1:0]       ctrl_f,
  output logic [N_DOM*N_DOM-1:0]   sdep_f
);
  import dcc_pkg::*;
  localparam int IW = AW - 2;

  logic [CTRL_W-1:0] ctrl_q [N_DOM];
  logic [N_DOM-1:0]  sdep_q [N_DOM];
  logic [IW-1:0]     wr_dom, rd_dom;
  logic [1:0]        wr_sel, rd_sel;
  logic [DW-1:0]     rd_mux;
  logic              unused_wd;

  assign wr_dom    = wr_addr[AW-1:2];
  assign wr_sel    = wr_addr[1:0];
  assign rd_dom    = rd_addr[AW-1:2];
  assign rd_sel    = rd_addr[1:0];
  assign unused_wd = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < N_DOM; d++) begin
        ctrl_q[d] <= '0;
        sdep_q[d] <= '0;
      end
    end else if (wr_valid) begin
      for (int d = 0; d < N_DOM; d++) begin
        if (wr_dom == IW'(d)) begin
          if (wr_sel == 2'd0) ctrl_q[d] <= wr_data[CTRL_W-1:0];
          if (wr_sel == 2'd1) sdep_q[d] <= wr_data[N_DOM-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int d = 0; d < N_DOM; d++) begin
      if (rd_dom == IW'(d)) begin
        case (rd_sel)
          2'd0: rd_mux[CTRL_W-1:0] = ctrl_q[d];
          2'd1: rd_mux[N_DOM-1:0]  = sdep_q[d];
          2'd2: begin
            rd_mux[0] = act[d];
            rd_mux[1] = awake[d];
            rd_mux[2] = clk_on[d];
            rd_mux[STAT_TRB +: N_DOM] = traffic[d*N_DOM +: N_DOM];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data       <= '0;
      rd_resp_valid <= 1'b0;
    end else begin
      rd_resp_valid <= rd_valid;
      if (rd_valid) rd_data <= rd_mux;
    end
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_flat
    assign ctrl_f[4*d +: 4]         = ctrl_q[d];
    assign sdep_f[d*N_DOM +: N_DOM] = sdep_q[d];
  end

  assert_rd_resp_R12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_resp_valid);
  assert_ctrl_stable_R12: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(ctrl_f) && $stable(sdep_f));
endmodule

// File: rtl/dcc_deps.sv
module dcc_deps #(
  parameter int N_DOM = 3
) (
  input  logic [N_DOM-1:0]       act,
  input  logic [N_DOM*N_DOM-1:0] sdep_f,
  input  logic [N_DOM*N_DOM-1:0] traffic,
  output logic [N_DOM-1:0]       hold
);
  // Self bits (s == d) are skipped: a domain cannot hold itself (R11).
  always_comb begin
    hold = '0;
    for (int d = 0; d < N_DOM; d++) begin
      for (int s = 0; s < N_DOM; s++) begin
        if (s != d) begin
          hold[d] = hold[d] | (act[s] & sdep_f[s*N_DOM+d]) | traffic[s*N_DOM+d];
        end
      end
    end
  end
endmodule

// File: rtl/dcc_dom_fsm.sv
module dcc_dom_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tmode_i,
  input  logic [1:0] mmode_i,
  input  logic       dep_hold,
  input  logic       wake_req,
  input  logic       idle_ack,
  output logic       clk_en_o,
  output logic       act_o,
  output logic       idle_req_o,
  output logic       awake_o,
  output logic       mclk_o
);
  import dcc_pkg::*;

  tmode_t  tmode;
  dstate_t st, nxt;
  logic    keep, want_on, mm_en;

  assign tmode = tmode_t'(tmode_i);
  assign keep  = (tmode == TM_KEEP);
  assign mm_en = (mmode_i == MM_AUTOGATE) || (mmode_i == MM_ON);

  always_comb begin
    case (tmode)
      TM_WAKE:  want_on = 1'b1;
      TM_SLEEP: want_on = dep_hold;
      TM_AUTO:  want_on = dep_hold | wake_req;
      default:  want_on = 1'b0;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF:    if (!keep && want_on) nxt = ST_UNGATE;
      ST_UNGATE: nxt = ST_ON;
      ST_ON: begin
        if (!keep) begin
          if (!want_on)   nxt = ST_IDLING;
          else if (mm_en) nxt = ST_WAKING;
        end
      end
      ST_WAKING: if (!idle_ack) nxt = ST_RUN;
      ST_RUN:    if (!keep && (!want_on || !mm_en)) nxt = ST_IDLING;
      ST_IDLING: if (idle_ack) nxt = (want_on && !keep) ? ST_ON : ST_GATE;
      ST_GATE:   nxt = (want_on && !keep) ? ST_UNGATE : ST_OFF;
      default:   nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OFF;
      clk_en_o   <= 1'b0;
      act_o      <= 1'b0;
      idle_req_o <= 1'b1;
      awake_o    <= 1'b0;
      mclk_o     <= 1'b0;
    end else begin
      st         <= nxt;
      clk_en_o   <= nxt inside {ST_ON, ST_WAKING, ST_RUN, ST_IDLING};
      act_o      <= (nxt != ST_OFF);
      idle_req_o <= !(nxt inside {ST_WAKING, ST_RUN});
      awake_o    <= (nxt == ST_RUN);
      case (mmode_i)
        MM_ON:       mclk_o <= nxt inside {ST_ON, ST_WAKING, ST_RUN, ST_IDLING};
        MM_AUTOGATE: mclk_o <= nxt inside {ST_WAKING, ST_RUN};
        default:     mclk_o <= 1'b0;
      endcase
    end
  end

  assert_keep_asleep_R2: assert property (@(posedge clk) disable iff (rst)
    (keep && !act_o) |=> !act_o);
  assert_module_needs_mode_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_req_o) |-> $past(mm_en));
  assert_awake_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(awake_o) |-> $past(!idle_ack));
  assert_gate_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_o) |-> $past(idle_ack));
  assert_gated_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !clk_en_o |-> idle_req_o);
  assert_dep_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (dep_hold && !keep && !act_o) |=> act_o);
  assert_sleep_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (tmode == TM_SLEEP && dep_hold) |=> act_o);
endmodule

// File: rtl/domain_clock_ctrl.sv
module domain_clock_ctrl #(
  parameter  int N_DOM = 3,
  parameter  int DW    = 32,
  localparam int AW    = $clog2(N_DOM) + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_resp_valid,
  input  logic [N_DOM-1:0]       wake_req,
  input  logic [N_DOM-1:0]       idle_ack,
  input  logic [N_DOM*N_DOM-1:0] bus_traffic,
  output logic [N_DOM-1:0]       clk_en,
  output logic [N_DOM-1:0]       mod_clk_en,
  output logic [N_DOM-1:0]       idle_req,
  output logic [N_DOM-1:0]       clk_active
);
  logic [4*N_DOM-1:0]       ctrl_f;
  logic [N_DOM*N_DOM-1:0]   sdep_f;
  logic [N_DOM-1:0]         hold, awake;

  assign wr_ready = 1'b1;
  assign rd_ready = 1'b1;

  dcc_regs #(.N_DOM(N_DOM), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_resp_valid(rd_resp_valid),
    .act(clk_active), .awake(awake), .clk_on(clk_en), .traffic(bus_traffic),
    .ctrl_f(ctrl_f), .sdep_f(sdep_f)
  );

  dcc_deps #(.N_DOM(N_DOM)) u_deps (
    .act(clk_active), .sdep_f(sdep_f), .traffic(bus_traffic), .hold(hold)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    dcc_dom_fsm u_fsm (
      .clk(clk), .rst(rst),
      .tmode_i(ctrl_f[4*d +: 2]), .mmode_i(ctrl_f[4*d+2 +: 2]),
      .dep_hold(hold[d]), .wake_req(wake_req[d]), .idle_ack(idle_ack[d]),
      .clk_en_o(clk_en[d]), .act_o(clk_active[d]), .idle_req_o(idle_req[d]),
      .awake_o(awake[d]), .mclk_o(mod_clk_en[d])
    );
  end
endmodule

// File: tb/domain_clock_ctrl_test.sv
`timescale 1ns/1ps
module domain_clock_ctrl_test;
  localparam int N  = 3;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0, rd_valid = 1'b0;
  logic          wr_ready, rd_ready, rd_resp_valid;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0]   wr_data = '0, rd_data;
  logic [N-1:0]  wake_req = '0, idle_ack = '1;
  logic [N*N-1:0] bus_traffic = '0;
  logic [N-1:0]  clk_en, mod_clk_en, idle_req, clk_active;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  domain_clock_ctrl uut (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_resp_valid(rd_resp_valid),
    .wake_req(wake_req), .idle_ack(idle_ack), .bus_traffic(bus_traffic),
    .clk_en(clk_en), .mod_clk_en(mod_clk_en), .idle_req(idle_req), .clk_active(clk_active)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R12 read response valid", {31'd0, rd_resp_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 clk_en", {29'd0, clk_en}, 0);
    check("R1 clk_active", {29'd0, clk_active}, 0);
    check("R1 mod_clk_en", {29'd0, mod_clk_en}, 0);
    check("R1 idle_req", {29'd0, idle_req}, 32'h7);
    rd(4'd0, v); check("R1 ctrl d0", v, 0);
    rd(4'd5, v); check("R1 sdep d1", v, 0);
  endtask

  task automatic t_keep;
    wake_req[0] = 1'b1;
    bus_traffic[1*N+0] = 1'b1;
    tick(5);
    check("R2 keep holds sleep", {31'd0, clk_active[0]}, 0);
    wake_req[0] = 1'b0;
    bus_traffic = '0;
  endtask

  task automatic t_force_wake;
    wr(4'd0, 32'h2);
    check("R3 no change yet", {31'd0, clk_active[0]}, 0);
    tick(1);
    check("R3 ungating activity", {31'd0, clk_active[0]}, 1);
    check("R3 ungating clk off", {31'd0, clk_en[0]}, 0);
    tick(1);
    check("R3 clk_en on", {31'd0, clk_en[0]}, 1);
  endtask

  task automatic t_no_module;
    logic [31:0] v;
    tick(4);
    check("R4 idle_req held", {31'd0, idle_req[0]}, 1);
    check("R4 mod clk off", {31'd0, mod_clk_en[0]}, 0);
    rd(4'd2, v); check("R4 status not awake", v, 32'h5);
  endtask

  task automatic t_module_on;
    logic [31:0] v;
    wr(4'd0, 32'hA);
    tick(1);
    check("R5 idle_req dropped", {31'd0, idle_req[0]}, 0);
    check("R5 mode2 mod clk", {31'd0, mod_clk_en[0]}, 1);
    tick(3);
    rd(4'd2, v); check("R5 awake waits ack", v, 32'h5);
    idle_ack[0] = 1'b0;
    tick(1);
    rd(4'd2, v); check("R5 awake after ack", v, 32'h7);
    wr(4'd0, 32'h6);
    tick(1);
    check("R5 mode1 mod clk in run", {31'd0, mod_clk_en[0]}, 1);
  endtask

  task automatic t_auto_sleep;
    wr(4'd0, 32'h7);
    tick(1);
    check("R6 idle_req raised", {31'd0, idle_req[0]}, 1);
    check("R6 clk kept", {31'd0, clk_en[0]}, 1);
    check("R5 mode1 mod clk gated", {31'd0, mod_clk_en[0]}, 0);
    tick(3);
    check("R6 clk waits ack", {31'd0, clk_en[0]}, 1);
    idle_ack[0] = 1'b1;
    tick(1);
    check("R6 gating clk off", {31'd0, clk_en[0]}, 0);
    check("R6 gating activity", {31'd0, clk_active[0]}, 1);
    tick(1);
    check("R6 asleep", {31'd0, clk_active[0]}, 0);
  endtask

  task automatic t_auto_wake;
    logic [31:0] v;
    wake_req[0] = 1'b1;
    tick(1);
    check("R7 wake activity", {31'd0, clk_active[0]}, 1);
    tick(2);
    check("R7 idle_req dropped", {31'd0, idle_req[0]}, 0);
    idle_ack[0] = 1'b0;
    tick(1);
    rd(4'd2, v); check("R7 awake", v, 32'h7);
    wake_req[0] = 1'b0;
    tick(1);
    idle_ack[0] = 1'b1;
    tick(3);
    check("R7 sleeps again", {31'd0, clk_active[0]}, 0);
  endtask

  task automatic t_static;
    wr(4'd4, 32'h3);
    tick(3);
    check("R8 d1 idle", {31'd0, clk_active[1]}, 0);
    wr(4'd1, 32'h2);
    tick(3);
    check("R8 asleep source no hold", {31'd0, clk_active[1]}, 0);
    wr(4'd0, 32'h2);
    tick(4);
    check("R8 d1 held active", {31'd0, clk_active[1]}, 1);
    check("R8 d1 clk on", {31'd0, clk_en[1]}, 1);
    wr(4'd0, 32'h3);
    tick(10);
    check("R8 d0 asleep", {31'd0, clk_active[0]}, 0);
    check("R8 d1 released", {31'd0, clk_active[1]}, 0);
  endtask

  task automatic t_self;
    wr(4'd1, 32'h3);
    wr(4'd0, 32'h2);
    tick(5);
    wr(4'd0, 32'h3);
    tick(10);
    check("R11 self bit ignored", {31'd0, clk_active[0]}, 0);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_force_sleep;
    wr(4'd8, 32'h1);
    tick(3);
    check("R10 d2 asleep", {31'd0, clk_active[2]}, 0);
    wr(4'd1, 32'h4);
    wr(4'd0, 32'h2);
    tick(5);
    check("R10 sleep blocked by dep", {31'd0, clk_active[2]}, 1);
    wr(4'd1, 32'h0);
    tick(6);
    check("R10 sleep honoured", {31'd0, clk_active[2]}, 0);
    wr(4'd0, 32'h3);
    tick(6);
  endtask

  task automatic t_dynamic;
    logic [31:0] v;
    bus_traffic[2*N+1] = 1'b1;
    tick(1);
    check("R9 traffic wakes d1", {31'd0, clk_active[1]}, 1);
    rd(4'd10, v); check("R9 dyn status bit", v, 32'h200);
    tick(4);
    check("R9 held while traffic", {31'd0, clk_active[1]}, 1);
    bus_traffic = '0;
    tick(8);
    check("R9 released", {31'd0, clk_active[1]}, 0);
    rd(4'd10, v); check("R9 status clear", v, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(4'd10, 32'hFFFF);
    rd(4'd10, v); check("R12 status read-only", v, 32'h0);
    wr(4'd5, 32'h1FF);
    rd(4'd5, v); check("R12 dep width", v, 32'h7);
    rd(4'd0, v); check("R12 ctrl readback", v, 32'h3);
    rd(4'd12, v); check("R12 no domain", v, 32'h0);
    rd(4'd3, v); check("R12 select 3", v, 32'h0);
    wr(4'd5, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_keep();
    t_force_wake();
    t_no_module();
    t_module_on();
    t_auto_sleep();
    t_auto_wake();
    t_static();
    t_self();
    t_force_sleep();
    t_dynamic();
    t_regs();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule